// File: doc/BRIEF.md
# Parallel SAR Converter Command and Read Sequencer

This block sits next to a successive-approximation converter that has a parallel result bus, two active-low control lines (a select line and a read/convert line) and a BUSY output that is low while a conversion runs. When asked, the block orders a conversion, waits for BUSY to fall and then rise again, and reads the result off the parallel bus. It then offers the sample on a valid/ready stream port. All the converter's timing rules are counted in clock cycles, and each has its own parameter.

A conversion starts only while both control lines are low. The parameter `TRIG_ON_RC` chooses which line fires the conversion. The other line goes low first and stays low for a set lead time. The block never orders a conversion while BUSY is low, because that would halt the conversion in progress and reset the converter. It keeps both lines high while BUSY is due to rise, and it keeps a minimum acquisition gap between two conversion commands. If BUSY stays at one level for too long, the block gives up on that conversion, pulses an error output and returns to idle.

The sample port follows valid/ready rules. Once `smp_valid_o` rises, it stays high, and `smp_data_o` holds its value, until the cycle in which `smp_ready_i` is also high. That cycle is the transfer. While a sample waits to be taken, no new conversion is started. Back-pressure on the port therefore stalls the converter, and no sample is ever lost.

Top module: `sar_read_seq`

## Requirements
- R1: During reset and just after it, both control outputs are high, and `smp_valid_o` and `tmo_err_o` are low.
- R2: Before each conversion command, the lead line is low on its own, with the trigger line still high, for exactly `SETUP_CYC` cycles. With `TRIG_ON_RC`=1 the lead line is `cs_n_o` and the trigger line is `rc_n_o`. With `TRIG_ON_RC`=0 the two roles are swapped.
- R3: Each conversion command keeps both control outputs low for exactly `PULSE_CYC` consecutive cycles.
- R4: A conversion command begins only if `busy_i` was high in the cycle before. While `busy_i` stays low, no command is started, even with a request pending.
- R5: Both control outputs stay high from the end of the command until BUSY has risen. So whenever `busy_i` rises, at least one control output is high.
- R6: After `busy_i` rises, `cs_n_o` is low and `rc_n_o` is high for exactly `RD_CYC` cycles. The bus value in the last of those cycles becomes the sample, and `smp_valid_o` rises in the first cycle after that window.
- R7: Two consecutive conversion commands start at least `ACQ_CYC` cycles apart.
- R8: While `smp_valid_o` is high and `smp_ready_i` is low, `smp_valid_o` stays high and `smp_data_o` keeps its value. No new conversion starts while a sample waits.
- R9: If `busy_i` does not fall, or does not rise again, within `BUSY_TO_CYC` cycles, `tmo_err_o` pulses high for one cycle and no sample is produced. When BUSY never falls, the pulse comes exactly `BUSY_TO_CYC` cycles after the command ends.
- R10: With `start_i` low, the block starts no conversion and both control outputs stay high. `start_i` is a level request: it is sampled while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Level request for conversions |
| busy_i | input | 1 | Converter BUSY, low while converting |
| cs_n_o | output | 1 | Active-low select toward the converter |
| rc_n_o | output | 1 | Read/convert line: low orders a conversion, high reads |
| rd_data_i | input | DW | Converter parallel result bus |
| smp_valid_o | output | 1 | Sample valid |
| smp_ready_i | input | 1 | Sample accepted by downstream |
| smp_data_o | output | DW | Sample value |
| tmo_err_o | output | 1 | One-cycle pulse on a BUSY timeout |

## Verification
A state machine stuck in the wrong state shows up at the control pins within one cycle. Both lines may fall together, the lead line may be missing, or the pulse may have the wrong length. Any of these breaks R2 or R3 at the very next command. A read that comes too early, before BUSY rises, puts the inverted bus value into the sample, so the mismatch appears in the transfer cycle. Wrong gap or timeout counters change the cycle distance between commands, or the cycle of the error pulse. These are checked cycle-exact for every command, across a sweep of BUSY delays and conversion lengths.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_WLO   = 3'd3,
    ST_WHI   = 3'd4,
    ST_READ  = 3'd5,
    ST_HOLD  = 3'd6
  } seq_st_e;
endpackage

// File: rtl/sar_rd_gap.sv
module sar_rd_gap #(
  parameter int ACQ_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);
  localparam int GW = $clog2(ACQ_CYC + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= GW'(ACQ_CYC - 1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sar_rd_fsm.sv
module sar_rd_fsm
  import sar_rd_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 5,
  parameter int BUSY_TO_CYC = 2000,
  parameter int RD_CYC      = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    busy_i,
  input  logic    slot_full_i,
  input  logic    gap_done_i,
  output seq_st_e st_o,
  output logic    gap_load_o,
  output logic    cap_o,
  output logic    err_o
);
  localparam int M1   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2   = (BUSY_TO_CYC > RD_CYC) ? BUSY_TO_CYC : RD_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] TO_LAST    = CW'(BUSY_TO_CYC - 1);
  localparam logic [CW-1:0] RD_LAST    = CW'(RD_CYC - 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tmo, err_q;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q + 1'b1;
    gap_load_o = 1'b0;
    cap_o      = 1'b0;
    tmo        = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_i && gap_done_i && !slot_full_i && busy_i)
          st_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (cnt_q == SETUP_LAST) begin
          cnt_d = '0;
          if (busy_i) begin
            st_d       = ST_PULSE;
            gap_load_o = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_PULSE: begin
        if (cnt_q == PULSE_LAST) begin
          cnt_d = '0;
          st_d  = ST_WLO;
        end
      end
      ST_WLO: begin
        if (!busy_i) begin
          cnt_d = '0;
          st_d  = ST_WHI;
        end else if (cnt_q == TO_LAST) begin
          cnt_d = '0;
          st_d  = ST_IDLE;
          tmo   = 1'b1;
        end
      end
      ST_WHI: begin
        if (busy_i) begin
          cnt_d = '0;
          st_d  = ST_READ;
        end else if (cnt_q == TO_LAST) begin
          cnt_d = '0;
          st_d  = ST_IDLE;
          tmo   = 1'b1;
        end
      end
      ST_READ: begin
        if (cnt_q == RD_LAST) begin
          cnt_d = '0;
          st_d  = ST_HOLD;
          cap_o = 1'b1;
        end
      end
      ST_HOLD: begin
        cnt_d = '0;
        if (gap_done_i)
          st_d = ST_IDLE;
      end
      default: begin
        cnt_d = '0;
        st_d  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      err_q <= tmo;
    end
  end

  assign st_o  = st_q;
  assign err_o = err_q;
endmodule

// File: rtl/sar_rd_drive.sv
module sar_rd_drive
  import sar_rd_pkg::*;
#(
  parameter bit TRIG_ON_RC = 1'b1
) (
  input  seq_st_e st_i,
  output logic    cs_n_o,
  output logic    rc_n_o
);
  logic in_setup, in_pulse, in_read;

  assign in_setup = (st_i == ST_SETUP);
  assign in_pulse = (st_i == ST_PULSE);
  assign in_read  = (st_i == ST_READ);

  generate
    if (TRIG_ON_RC) begin : g_cs_leads
      assign cs_n_o = !(in_setup || in_pulse || in_read);
      assign rc_n_o = !in_pulse;
    end else begin : g_rc_leads
      assign cs_n_o = !(in_pulse || in_read);
      assign rc_n_o = !(in_setup || in_pulse);
    end
  endgenerate
endmodule

// File: rtl/sar_rd_slot.sv
module sar_rd_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (cap_i) begin
      vld_q <= 1'b1;
      dat_q <= data_i;
    end else if (vld_q && ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;
endmodule

// File: rtl/sar_read_seq.sv
module sar_read_seq
  import sar_rd_pkg::*;
#(
  parameter int DW          = 16,
  parameter bit TRIG_ON_RC  = 1'b1,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 5,
  parameter int BUSY_TO_CYC = 2000,
  parameter int RD_CYC      = 4,
  parameter int ACQ_CYC     = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          busy_i,
  output logic          cs_n_o,
  output logic          rc_n_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          smp_valid_o,
  input  logic          smp_ready_i,
  output logic [DW-1:0] smp_data_o,
  output logic          tmo_err_o
);
  seq_st_e st;
  logic    gap_load, gap_done, cap;

  sar_rd_gap #(.ACQ_CYC(ACQ_CYC)) gap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (gap_load),
    .done_o (gap_done)
  );

  sar_rd_fsm #(
    .SETUP_CYC   (SETUP_CYC),
    .PULSE_CYC   (PULSE_CYC),
    .BUSY_TO_CYC (BUSY_TO_CYC),
    .RD_CYC      (RD_CYC)
  ) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_i      (busy_i),
    .slot_full_i (smp_valid_o),
    .gap_done_i  (gap_done),
    .st_o        (st),
    .gap_load_o  (gap_load),
    .cap_o       (cap),
    .err_o       (tmo_err_o)
  );

  sar_rd_drive #(.TRIG_ON_RC(TRIG_ON_RC)) drv_i (
    .st_i   (st),
    .cs_n_o (cs_n_o),
    .rc_n_o (rc_n_o)
  );

  sar_rd_slot #(.DW(DW)) slot_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (cap),
    .data_i  (rd_data_i),
    .ready_i (smp_ready_i),
    .valid_o (smp_valid_o),
    .data_o  (smp_data_o)
  );
endmodule

// File: rtl/sar_rd_chk.sv
module sar_rd_chk #(
  parameter int DW         = 16,
  parameter bit TRIG_ON_RC = 1'b1,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 5,
  parameter int ACQ_CYC    = 400
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rc_n,
  input logic          busy,
  input logic          valid,
  input logic          ready,
  input logic [DW-1:0] data,
  input logic          err
);
  logic conv, conv_q, lead_n, seen_q;
  int   pulse_run, lead_run, gap_run;

  assign conv   = !cs_n && !rc_n;
  assign lead_n = TRIG_ON_RC ? cs_n : rc_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_q    <= 1'b0;
      seen_q    <= 1'b0;
      pulse_run <= 0;
      lead_run  <= 0;
      gap_run   <= 0;
    end else begin
      conv_q    <= conv;
      pulse_run <= conv ? pulse_run + 1 : 0;
      lead_run  <= (!lead_n && !conv) ? lead_run + 1 : 0;
      if (conv && !conv_q) begin
        gap_run <= 1;
        seen_q  <= 1'b1;
      end else if (gap_run < ACQ_CYC) begin
        gap_run <= gap_run + 1;
      end
    end
  end

  p_lead_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv) |-> lead_run == SETUP_CYC);

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv) |-> pulse_run == PULSE_CYC);

  p_no_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv) |-> $past(busy));

  p_high_at_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !conv);

  p_acq_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(conv) && seen_q) |-> gap_run >= ACQ_CYC);

  p_hold_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

bind sar_read_seq sar_rd_chk #(
  .DW         (DW),
  .TRIG_ON_RC (TRIG_ON_RC),
  .SETUP_CYC  (SETUP_CYC),
  .PULSE_CYC  (PULSE_CYC),
  .ACQ_CYC    (ACQ_CYC)
) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_n  (cs_n_o),
  .rc_n  (rc_n_o),
  .busy  (busy_i),
  .valid (smp_valid_o),
  .ready (smp_ready_i),
  .data  (smp_data_o),
  .err   (tmo_err_o)
);

// File: tb/sar_read_seq_tb_top.sv
module sar_read_seq_tb_top;
  localparam int DW    = 8;
  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int TO    = 20;
  localparam int RD    = 2;
  localparam int ACQ   = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start, busy, cs_n, rc_n, valid, ready, err;
  logic [DW-1:0] rd_data, smp_data, sample;
  logic          have;

  sar_read_seq #(
    .DW(DW), .TRIG_ON_RC(1'b1), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
    .BUSY_TO_CYC(TO), .RD_CYC(RD), .ACQ_CYC(ACQ)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy),
    .cs_n_o(cs_n), .rc_n_o(rc_n), .rd_data_i(rd_data),
    .smp_valid_o(valid), .smp_ready_i(ready), .smp_data_o(smp_data),
    .tmo_err_o(err)
  );

  int vecs = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: mode 0 normal, 1 BUSY never falls, 2 BUSY never rises
  int mode = 0, lat = 0, clen = 1, ph = 0, mcnt = 0, nconv = 0, aborts = 0;
  logic mprev;

  assign rd_data = (have && !cs_n && rc_n) ? sample : ~sample;

  always @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b1;
      have  <= 1'b0;
      sample <= '0;
      mprev = 1'b0;
      ph = 0;
    end else begin
      if (!cs_n && !rc_n && !mprev) begin
        nconv++;
        sample <= DW'(nconv * 37 + 11);
        have   <= 1'b0;
        if (!busy) aborts++;
        if (mode != 1) begin
          ph = 1;
          mcnt = lat;
        end
      end else if (ph == 1) begin
        if (mcnt == 0) begin
          busy <= 1'b0;
          ph = 2;
          mcnt = clen;
        end else mcnt--;
      end else if (ph == 2 && mode != 2) begin
        if (mcnt == 0) begin
          busy <= 1'b1;
          have <= 1'b1;
          ph = 0;
        end else mcnt--;
      end
      mprev = !cs_n && !rc_n;
    end
  end

  // port monitor, sampled on the falling edge
  bit pconv = 0, pbusy = 1, pvalid = 0, pready = 0, perr = 0, seen = 0, rdarm = 0;
  logic [DW-1:0] pdata = '0;
  int lead = 0, both = 0, gap = 0, rdlen = 0, tcnt = 0, acc = 0, nerr = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit conv = !cs_n && !rc_n;
      if (conv && !pconv) begin
        chk(lead == SETUP, "R2 lead time", lead, SETUP);
        chk(pbusy, "R4 busy high before command", int'(pbusy), 1);
        if (seen) chk(gap >= ACQ, "R7 command spacing", gap, ACQ);
        gap = 0; seen = 1; both = 0; rdarm = 0;
      end else gap++;
      if (conv) both++;
      if (!conv && pconv) begin
        chk(both == PULSE, "R3 pulse width", both, PULSE);
        tcnt = 0;
      end else tcnt++;
      if (!cs_n && rc_n) lead++; else lead = 0;
      if (busy && !pbusy) begin
        chk(!conv, "R5 line high at busy rise", int'(conv), 0);
        rdarm = 1; rdlen = 0;
      end else if (rdarm) begin
        if (!cs_n && rc_n) rdlen++;
        else if (rdlen > 0) begin
          chk(rdlen == RD, "R6 read window", rdlen, RD);
          chk(valid && !pvalid, "R6 valid timing", int'(valid), 1);
          rdarm = 0;
        end
      end
      if (err) begin
        if (mode == 1) chk(tcnt == TO, "R9 timeout cycle", tcnt, TO);
        chk(!valid, "R9 no sample on timeout", int'(valid), 0);
        chk(!perr, "R9 single-cycle pulse", int'(perr), 0);
        nerr++;
      end
      if (pvalid && !pready) begin
        chk(valid, "R8 valid held", int'(valid), 1);
        chk(smp_data == pdata, "R8 data stable", int'(smp_data), int'(pdata));
      end
      if (valid && ready) begin
        chk(smp_data == sample, "R6 sample value", int'(smp_data), int'(sample));
        acc++;
      end
      pconv = conv; pbusy = busy; pvalid = valid; pready = ready;
      perr = err; pdata = smp_data;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", acc, 0);
    summary();
  end

  initial begin
    int a0, n1, e0;
    rst_n = 1'b0; start = 1'b0; ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(cs_n && rc_n, "R1 lines high in reset", int'({cs_n, rc_n}), 3);
    chk(!valid && !err, "R1 outputs low in reset", int'({valid, err}), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(cs_n && rc_n && !valid && !err, "R1 idle after reset",
        int'({cs_n, rc_n, valid, err}), 12);

    // R10: no request, no command
    repeat (30) @(posedge clk);
    #1;
    chk(nconv == 0, "R10 no command without start", nconv, 0);
    chk(cs_n && rc_n, "R10 lines stay high", int'({cs_n, rc_n}), 3);

    // sweep of BUSY fall delay and conversion length
    start = 1'b1;
    for (int l = 0; l < 3; l++) begin
      for (int c = 0; c < 4; c++) begin
        lat = l; clen = c * 3 + 1;
        a0 = acc;
        while (acc == a0) @(posedge clk);
        #1;
      end
    end

    // R8: back-pressure stalls the converter
    ready = 1'b0;
    while (!valid) @(posedge clk);
    #1;
    n1 = nconv;
    repeat (40) @(posedge clk);
    #1;
    chk(nconv == n1, "R8 no command while sample waits", nconv, n1);
    chk(valid, "R8 sample still offered", int'(valid), 1);
    ready = 1'b1;
    a0 = acc;
    while (acc == a0) @(posedge clk);
    #1;

    // R9: BUSY never falls
    mode = 1;
    e0 = nerr;
    while (nerr == e0) @(posedge clk);
    #1;
    mode = 0;
    a0 = acc;
    while (acc == a0) @(posedge clk);
    #1;
    chk(acc == a0 + 1, "R9 recovery after timeout", acc, a0 + 1);

    // R9 and R4: BUSY falls and never rises
    mode = 2;
    e0 = nerr;
    while (nerr == e0) @(posedge clk);
    #1;
    n1 = nconv;
    repeat (50) @(posedge clk);
    #1;
    chk(nconv == n1, "R4 no command while busy low", nconv, n1);
    mode = 0;
    a0 = acc;
    while (acc == a0) @(posedge clk);
    #1;
    chk(aborts == 0, "R4 no aborted conversion", aborts, 0);
    start = 1'b0;
    repeat (5) @(posedge clk);
    summary();
  end
endmodule